// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a byte-wide serial port that moves data over one clock line and one data line. It runs either as clock master, producing the transfer clock from its own divider, or as slave, following a clock that arrives from outside. One shift register does the serialising. A transmit holding register and a receive holding register sit on either side of it, so software can load the next byte or collect the last one while a transfer is still in progress.

A small register-style host port sets the mode and moves data. It also reports three flags: transmit holding register free, receive holding register full, and receive overrun. In master receive the clock keeps running from byte to byte for as long as software drains the receive register. A stop request ends reception cleanly: the byte in flight finishes and the clock then parks high. When a transmit byte is not written in time, the block stops the clock rather than send stale data.

Top module: `sspt_top`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x01, `sclk_o` is 1 and both `sclk_oe` and `sda_oe` are 0.
- R2: The host reaches four registers through `host_addr`. Address 0 is control: bit 0 enable, bit 1 master, bit 2 transmit direction, bit 3 receive stop, bits 7:4 divider select. It reads back as written. Address 1 is status: bit 0 transmit-empty, bit 1 receive-full, bit 2 overrun. Address 2 is write-only transmit data. Address 3 is read-only receive data.
- R3: As master, the clock high and low phases each last (divider select + 1) system clocks. The clock is 1 whenever no byte is in progress. `sclk_oe` equals enable AND master.
- R4: A transmitted byte goes out least significant bit first over eight clock periods. `sda_o` changes after a falling clock edge and is stable at the following rising edge.
- R5: Transmit-empty becomes 1 when a byte moves from the holding register into the shift register. A byte written before the current byte's eighth rising edge follows it with no gap in the clock.
- R6: If transmit-empty is still 1 at a byte's eighth rising edge, the master clock stops high after that byte.
- R7: In receive, `sda_i` is sampled on each rising clock edge, least significant bit first. After the eighth edge the byte is placed in the receive register and receive-full is set.
- R8: In master receive the clock runs on continuously from byte to byte. Reading address 3 clears receive-full.
- R9: If a byte's eighth rising edge arrives while receive-full is 1, overrun is set and the receive register keeps its earlier byte. Overrun stays 1 until the host writes address 1 with bit 2 equal to 0.
- R10: In master receive with receive stop set, the byte in progress completes, no new byte starts, and the clock parks high.
- R11: As slave, `sclk_i` passes through a two-flop synchronizer, and its edges drive both receive and transmit in the same way as in master mode. `sclk_oe` stays 0 and `sclk_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 2 | Register select |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (a read of address 3 clears receive-full) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| sclk_i | input | 1 | Transfer clock from outside (slave) |
| sclk_o | output | 1 | Transfer clock driven by the block (master) |
| sclk_oe | output | 1 | Enable for the clock line driver |
| sda_i | input | 1 | Serial data in |
| sda_o | output | 1 | Serial data out |
| sda_oe | output | 1 | Enable for the data line driver (transmit direction) |

## Verification
The hardest conditions to reach from the ports are the overrun at a byte's eighth rising edge and the one-more-byte stop. Both depend on when host accesses happen relative to serial edges that the block generates itself. The bench runs a peer model that shifts a prepared bit stream onto `sda_i` on every falling edge of `sclk_o`. To force the overrun, it holds back the read of the receive register. To exercise the stop, it sets the stop bit while a later byte is already in flight, then counts rising clock edges to confirm that exactly one more byte was clocked.

// File: rtl/sspt_pkg.sv
// Shared register addresses and the control register layout for the
// synchronous serial transceiver. Assumes an 8-bit host data path.
package sspt_pkg;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_TXD  = 2'd2;
    localparam logic [1:0] A_RXD  = 2'd3;
    localparam int         S_OVR  = 2;

    typedef struct packed {
        logic [3:0] sel;
        logic       stop;
        logic       tx;
        logic       mst;
        logic       en;
    } ctrl_t;
endpackage

// File: rtl/sspt_clkgen.sv
// Transfer clock source. As master it divides clk down to phases of
// (sel+1) cycles while run is high, and parks high otherwise. As slave it
// synchronizes sclk_in. rise/fall mark the clk edge at which the line
// changes (master) or at which a synchronized edge is seen (slave).
// Assumes sel is held steady while run is high.
module sspt_clkgen #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    input  logic             sclk_in,
    output logic             sclk_out,
    output logic             rise,
    output logic             fall
);
    logic [SEL_W-1:0] div_q;
    logic             sclk_q;
    logic [2:0]       sync_q;
    logic             tick;

    assign tick = (div_q == sel);

    // divider and master clock line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            sclk_q <= 1'b1;
        end else if (mst && run) begin
            if (tick) begin
                div_q  <= '0;
                sclk_q <= ~sclk_q;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end else begin
            div_q  <= '0;
            sclk_q <= 1'b1;
        end
    end

    // two-flop synchronizer plus one history flop for slave edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 3'b111;
        else        sync_q <= {sync_q[1:0], sclk_in};
    end

    // edge pulses from whichever clock source is selected
    always_comb begin
        if (mst) begin
            rise = run && tick && !sclk_q;
            fall = run && tick &&  sclk_q;
        end else begin
            rise = sync_q[1] && !sync_q[2];
            fall = !sync_q[1] && sync_q[2];
        end
    end

    assign sclk_out = sclk_q;

    a_r3_parks_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mst && !run) |=> sclk_q);
    a_r3_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mst && run && !tick) |=> $stable(sclk_q));
endmodule

// File: rtl/sspt_engine.sv
// Byte engine: shift register, bit counter, holding registers and flags.
// Acts on rise/fall pulses from the clock source. Transmit shifts out on
// fall; receive samples on rise. Assumes the mode bits change only while
// disabled or idle.
module sspt_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              mst,
    input  logic              tx_mode,
    input  logic              rx_stop,
    input  logic              rise,
    input  logic              fall,
    input  logic              sda_in,
    input  logic              wr_tx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_rx,
    input  logic              clr_ovr,
    output logic              active,
    output logic              sda_out,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              overrun,
    output logic [DATA_W-1:0] rx_data
);
    localparam int                CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  bit_q;
    logic [DATA_W-1:0] shift_q, txbuf_q, rxbuf_q, rx_word;
    logic              active_q, sda_q, tx_empty_q, rx_full_q, ovr_q;
    logic              byte_end, start_tx, start_rx, tx_load;

    assign byte_end = active_q && rise && (bit_q == LAST);
    assign rx_word  = {sda_in, shift_q[DATA_W-1:1]};
    assign start_tx = en && tx_mode && !active_q && !tx_empty_q;
    assign start_rx = en && !tx_mode && !active_q && !(mst && rx_stop);
    assign tx_load  = start_tx || (byte_end && tx_mode && !tx_empty_q);

    // transfer sequencing: start, shift, count, continue or stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            bit_q    <= '0;
            shift_q  <= '0;
            sda_q    <= 1'b1;
        end else if (!en) begin
            active_q <= 1'b0;
            bit_q    <= '0;
        end else if (!active_q) begin
            if (start_tx) begin
                shift_q  <= txbuf_q;
                active_q <= 1'b1;
                bit_q    <= '0;
            end else if (start_rx) begin
                active_q <= 1'b1;
                bit_q    <= '0;
            end
        end else begin
            if (fall && tx_mode) begin
                sda_q   <= shift_q[0];
                shift_q <= shift_q >> 1;
            end
            if (rise) begin
                bit_q <= bit_q + 1'b1;
                if (!tx_mode) shift_q <= rx_word;
                if (byte_end) begin
                    bit_q <= '0;
                    if (tx_mode) begin
                        if (!tx_empty_q) shift_q <= txbuf_q;
                        else             active_q <= 1'b0;
                    end else if (mst && rx_stop) begin
                        active_q <= 1'b0;
                    end
                end
            end
        end
    end

    // transmit holding register and its empty flag (host write wins)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txbuf_q    <= '0;
            tx_empty_q <= 1'b1;
        end else begin
            if (tx_load) tx_empty_q <= 1'b1;
            if (wr_tx) begin
                txbuf_q    <= wr_data;
                tx_empty_q <= 1'b0;
            end
        end
    end

    // receive holding register, full flag and sticky overrun
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxbuf_q   <= '0;
            rx_full_q <= 1'b0;
            ovr_q     <= 1'b0;
        end else begin
            if (rd_rx)   rx_full_q <= 1'b0;
            if (clr_ovr) ovr_q     <= 1'b0;
            if (byte_end && !tx_mode) begin
                if (rx_full_q) begin
                    ovr_q <= 1'b1;
                end else begin
                    rxbuf_q   <= rx_word;
                    rx_full_q <= 1'b1;
                end
            end
        end
    end

    assign active   = active_q;
    assign sda_out  = sda_q;
    assign tx_empty = tx_empty_q;
    assign rx_full  = rx_full_q;
    assign overrun  = ovr_q;
    assign rx_data  = rxbuf_q;

    a_r9_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && !tx_mode && rx_full_q && !rd_rx) |=> (ovr_q && $stable(rxbuf_q)));
    a_r5_reload_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && tx_mode && !tx_empty_q && !wr_tx) |=> tx_empty_q);
    a_r6_underrun_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && tx_mode && tx_empty_q) |=> !active_q);
    a_r10_stop_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && !tx_mode && mst && rx_stop) |=> !active_q);
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && !byte_end) |=> !rx_full_q);
endmodule

// File: rtl/sspt_top.sv
// Synchronous serial transceiver top: host register decode, control
// register, and the wiring of the clock source to the byte engine.
// Assumes single-cycle host strobes and an 8-bit data path.
module sspt_top
    import sspt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] host_addr,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       sclk_i,
    output logic       sclk_o,
    output logic       sclk_oe,
    input  logic       sda_i,
    output logic       sda_o,
    output logic       sda_oe
);
    ctrl_t      ctrl_q;
    logic       rise_w, fall_w, active_w;
    logic       txe_w, rxf_w, ovr_w;
    logic [7:0] rxd_w;
    logic       wr_tx, rd_rx, clr_ovr;

    assign wr_tx   = host_wr && (host_addr == A_TXD);
    assign rd_rx   = host_rd && (host_addr == A_RXD);
    assign clr_ovr = host_wr && (host_addr == A_STAT) && !host_wdata[S_OVR];

    // control register
    always_ff @(posedge clk) begin
        if (!rst_n)                              ctrl_q <= '0;
        else if (host_wr && host_addr == A_CTRL) ctrl_q <= ctrl_t'(host_wdata);
    end

    // read data selection
    always_comb begin
        unique case (host_addr)
            A_CTRL:  host_rdata = ctrl_q;
            A_STAT:  host_rdata = {5'b0, ovr_w, rxf_w, txe_w};
            A_TXD:   host_rdata = 8'h00;
            default: host_rdata = rxd_w;
        endcase
    end

    sspt_clkgen #(.SEL_W(4)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .mst      (ctrl_q.mst),
        .run      (active_w && ctrl_q.en),
        .sel      (ctrl_q.sel),
        .sclk_in  (sclk_i),
        .sclk_out (sclk_o),
        .rise     (rise_w),
        .fall     (fall_w)
    );

    sspt_engine #(.DATA_W(8)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl_q.en),
        .mst      (ctrl_q.mst),
        .tx_mode  (ctrl_q.tx),
        .rx_stop  (ctrl_q.stop),
        .rise     (rise_w),
        .fall     (fall_w),
        .sda_in   (sda_i),
        .wr_tx    (wr_tx),
        .wr_data  (host_wdata),
        .rd_rx    (rd_rx),
        .clr_ovr  (clr_ovr),
        .active   (active_w),
        .sda_out  (sda_o),
        .tx_empty (txe_w),
        .rx_full  (rxf_w),
        .overrun  (ovr_w),
        .rx_data  (rxd_w)
    );

    assign sclk_oe = ctrl_q.en && ctrl_q.mst;
    assign sda_oe  = ctrl_q.en && ctrl_q.tx;

    a_r3_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_w && fall_w));
    a_r11_slave_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.mst && $past(!ctrl_q.mst)) |-> sclk_o);
endmodule

// File: tb/tb_sspt_top.sv
module tb_sspt_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [19:0] TX_VEC [4] = '{20'h1A53C, 20'h28001, 20'h000FF, 20'h3C35A};

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00, host_rdata;
    logic       sclk_i = 1'b1, sclk_o, sclk_oe;
    logic       sda_i = 1'b1, sda_o, sda_oe;

    int n_chk = 0, n_err = 0, cyc = 0;
    int cap_n = 0, peer_pos = 64;
    logic cap [64];
    int   rise_t [64];
    logic [63:0] peer_bits = '0;

    sspt_top dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // capture sda_o at each rising master clock edge
    initial forever begin
        @(posedge sclk_o);
        @(negedge clk);
        if (cap_n < 64) begin
            cap[cap_n] = sda_o;
            rise_t[cap_n] = cyc;
            cap_n++;
        end
    end

    // remote transmitter: next bit on each falling master clock edge
    initial forever begin
        @(negedge sclk_o);
        @(negedge clk);
        if (peer_pos < 64) begin
            sda_i = peer_bits[peer_pos];
            peer_pos++;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_stat(input logic [7:0] mask, input logic [7:0] val);
        logic [7:0] s;
        for (int t = 0; t < 3000; t++) begin
            rd(2'd1, s);
            if ((s & mask) == val) return;
        end
    endtask

    task automatic wait_caps(input int n);
        for (int t = 0; t < 3000 && cap_n < n; t++) @(negedge clk);
    endtask

    function automatic logic [7:0] cap_byte(input int base);
        logic [7:0] b;
        for (int j = 0; j < 8; j++) b[j] = cap[base + j];
        return b;
    endfunction

    initial begin
        logic [7:0] d;
        logic [7:0] sb;
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(2'd0, d); check("R1 control after reset", d, 8'h00);
        rd(2'd1, d); check("R1 status after reset", d, 8'h01);
        check("R1 sclk_o idle", sclk_o, 1'b1);
        check("R1 sclk_oe", sclk_oe, 1'b0);
        check("R1 sda_oe", sda_oe, 1'b0);

        // R2 control register read back, not enabled
        wr(2'd0, 8'hF4); rd(2'd0, d); check("R2 control readback", d, 8'hF4);
        wr(2'd0, 8'h00);

        // R3 R4 R5 R6 master transmit vectors
        for (int v = 0; v < 4; v++) begin
            logic [3:0] sel;
            logic [7:0] b0, b1;
            int half;
            sel = TX_VEC[v][19:16]; b1 = TX_VEC[v][15:8]; b0 = TX_VEC[v][7:0];
            half = int'(sel) + 1;
            wr(2'd0, 8'h00);
            cap_n = 0;
            wr(2'd0, {sel, 4'b0111});
            check("R3 sclk_oe in master", sclk_oe, 1'b1);
            wr(2'd2, b0);
            wait_stat(8'h01, 8'h01);
            wr(2'd2, b1);
            wait_caps(16);
            idle(8 * half + 4);
            check("R6 rising edges after underrun", cap_n, 16);
            check("R6 clock parked high", sclk_o, 1'b1);
            check("R4 first byte LSB first", cap_byte(0), b0);
            check("R5 second byte", cap_byte(8), b1);
            check("R3 clock period", rise_t[1] - rise_t[0], 2 * half);
            check("R5 no gap between bytes", rise_t[8] - rise_t[7], 2 * half);
        end
        wr(2'd0, 8'h00);

        // R7 R8 R10 master continuous receive and stop request
        peer_bits = {32'h0, 8'h81, 8'h0F, 8'hA5, 8'h3C};
        peer_pos = 0; cap_n = 0;
        wr(2'd0, {4'd1, 4'b0011});
        for (int k = 0; k < 4; k++) begin
            logic [7:0] e;
            e = peer_bits[8*k +: 8];
            wait_stat(8'h02, 8'h02);
            if (k == 2) wr(2'd0, {4'd1, 4'b1011});
            rd(2'd3, d);
            check("R7 R8 received byte", d, e);
        end
        idle(40);
        check("R10 one more byte then stop", cap_n, 32);
        check("R10 clock parked high", sclk_o, 1'b1);
        rd(2'd1, d); check("R8 read cleared receive-full", d, 8'h01);
        wr(2'd0, 8'h00);

        // R9 overrun keeps the earlier byte, sticky until cleared
        peer_bits = {48'h0, 8'h66, 8'hC9};
        peer_pos = 0; cap_n = 0;
        wr(2'd0, {4'd1, 4'b0011});
        wait_stat(8'h02, 8'h02);
        wr(2'd0, {4'd1, 4'b1011});
        wait_caps(16);
        idle(20);
        check("R10 stop after second byte", cap_n, 16);
        rd(2'd1, d); check("R9 overrun and full set", d, 8'h07);
        wr(2'd1, 8'h04);
        rd(2'd1, d); check("R9 write with bit2=1 keeps overrun", d, 8'h07);
        wr(2'd1, 8'h00);
        rd(2'd1, d); check("R9 overrun cleared by write of 0", d, 8'h03);
        rd(2'd3, d); check("R9 earlier byte kept", d, 8'hC9);
        rd(2'd1, d); check("R8 receive-full cleared", d, 8'h01);
        wr(2'd0, 8'h00);

        // R11 slave receive on external clock
        sb = 8'hB4;
        wr(2'd0, 8'h01);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); sclk_i = 1'b0; sda_i = sb[i];
            idle(4);
            sclk_i = 1'b1;
            idle(4);
        end
        idle(4);
        check("R11 slave sclk_oe", sclk_oe, 1'b0);
        check("R11 slave sclk_o high", sclk_o, 1'b1);
        rd(2'd1, d); check("R11 slave receive-full", d, 8'h03);
        rd(2'd3, d); check("R11 slave received byte", d, sb);
        wr(2'd0, 8'h00);

        // R11 slave transmit on external clock
        sb = 8'h4D;
        wr(2'd0, 8'h05);
        wr(2'd2, sb);
        idle(2);
        check("R11 slave sda_oe", sda_oe, 1'b1);
        rd(2'd1, d); check("R5 slave load sets transmit-empty", d, 8'h01);
        d = 8'h00;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); sclk_i = 1'b0;
            idle(6);
            d[i] = sda_o;
            sclk_i = 1'b1;
            idle(6);
        end
        check("R11 slave transmitted byte", d, sb);
        wr(2'd0, 8'h00);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule